// File: doc/BRIEF.md
# Speculative Credit Link

This block joins a link sender and a link receiver that use credit flow control, with one addition. When the sender has no credit and nothing else could go, it may send a cell anyway. The receiver keeps a small buffer. A cell that arrives while that buffer is full is thrown away and answered with a negative acknowledgement that carries the cell's tag. Any other arriving cell is stored and answered with a positive acknowledgement. Every cell the sender transmits stays in a small retransmission store, indexed by its tag, until a positive acknowledgement frees it.

The credit counter is signed, so a speculative send can take it below zero. A negative acknowledgement returns one credit, because the dropped cell never took a buffer slot. A consumer pop returns one credit on the cycle after the pop. A cell that was refused is marked for resend. It may go again only when the counter is positive, and it goes ahead of cells that have never been sent. Because of this, cells can reach the consumer in a different order from the one in which they were accepted. Each accepted cell is still delivered exactly once.

The link, the response path and the credit return are all brought out as outputs, so the handshake between the two halves can be observed.

Top module: `spec_credit_link`

## Requirements
- R1: After reset, `up_ready_o` is 1 and `link_valid_o`, `cons_valid_o` and all response outputs are 0. From then on, `up_ready_o` is 1 exactly when fewer than STORE_DEPTH cells are held, counting a cell as held from its upstream handshake until the edge after its positive acknowledgement appears on `resp_ack_o`.
- R2: The credit counter starts at RX_DEPTH. On each edge it loses one for a send and gains one for each of `resp_credit_o` and `resp_nack_o` present in the cycle before. A send with `link_spec_o`=0 happens only when the counter is above zero.
- R3: A send with `link_spec_o`=1 happens only when the counter is zero or below.
- R4: A cell is sent speculatively at most once, and only on its first transmission.
- R5: A refused cell is resent only with credit (`link_spec_o`=0). Once it has been eligible for a cycle, a positive counter sends it ahead of any never-sent cell.
- R6: A cell is sent again only after a negative acknowledgement for it.
- R7: One cycle after a cell is on the link, exactly one of `resp_ack_o`/`resp_nack_o` is 1 and `resp_tag_o` equals that cell's tag. The answer is a negative acknowledgement exactly when the receive buffer held RX_DEPTH cells in the arrival cycle; a consumer pop in that same cycle does not make room.
- R8: `resp_credit_o` is 1 exactly in the cycle after a consumer pop (`cons_valid_o` and `cons_ready_i` both 1).
- R9: Every accepted cell reaches the consumer exactly once with unchanged data. A cell sent with credit is never refused.
- R10: `cons_valid_o` is 1 exactly when the receive buffer is not empty, and a presented cell stays presented until it is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_valid_i | input | 1 | Upstream cell offered |
| up_data_i | input | DATA_W | Upstream cell payload |
| up_ready_o | output | 1 | Retransmission store has a free slot |
| link_valid_o | output | 1 | Cell on the link this cycle |
| link_data_o | output | DATA_W | Link cell payload |
| link_tag_o | output | TAG_W | Store slot of the link cell |
| link_spec_o | output | 1 | Link cell was sent without credit |
| resp_ack_o | output | 1 | Positive acknowledgement |
| resp_nack_o | output | 1 | Negative acknowledgement (cell dropped) |
| resp_tag_o | output | TAG_W | Tag of the answered cell |
| resp_credit_o | output | 1 | One credit returned for a consumer pop |
| cons_valid_o | output | 1 | Receive buffer has a cell |
| cons_data_o | output | DATA_W | Oldest cell in the receive buffer |
| cons_ready_i | input | 1 | Consumer takes the presented cell |

## Verification
Two events can fall in the same cycle. In one, a speculative cell reaches a full buffer while the consumer pops. That cycle yields a drop and a pop credit together, so the counter gains two on the next edge. In the other, a negative acknowledgement makes a cell eligible for resend while never-sent cells are waiting. Both are provoked by sweeping every 4-cycle consumer-ready pattern against several upstream patterns, with a buffer of two and a store of four, so the sender is regularly pushed below zero credit. The bench rebuilds the buffer occupancy and the credit count from the ports. It judges each drop against the occupancy of the arrival cycle, and each send's speculative flag against the rebuilt count.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_NEW  = 2'd1,
    SLOT_WAIT = 2'd2,
    SLOT_RETX = 2'd3
  } slot_state_e;
endpackage

// File: rtl/scl_lowest_pick.sv
module scl_lowest_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/scl_credit_ctr.sv
module scl_credit_ctr #(
  parameter int CNT_W = 4,
  parameter int INIT  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    take_i,
  input  logic                    give_nack_i,
  input  logic                    give_pop_i,
  output logic signed [CNT_W-1:0] credit_o,
  output logic                    credit_ok_o
);
  logic signed [CNT_W-1:0] credit_q, credit_d;

  always_comb begin
    credit_d = credit_q - CNT_W'(take_i) + CNT_W'(give_nack_i) + CNT_W'(give_pop_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= CNT_W'(INIT);
    else         credit_q <= credit_d;
  end

  assign credit_o    = credit_q;
  assign credit_ok_o = !credit_q[CNT_W-1] && (credit_q != '0);
endmodule

// File: rtl/scl_tx_store.sv
module scl_tx_store
  import scl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_valid_i,
  input  logic [DATA_W-1:0] up_data_i,
  output logic              up_ready_o,
  input  logic              credit_ok_i,
  input  logic              ack_i,
  input  logic              nack_i,
  input  logic [TAG_W-1:0]  resp_tag_i,
  output logic              send_o,
  output logic [TAG_W-1:0]  send_tag_o,
  output logic [DATA_W-1:0] send_data_o,
  output logic              send_spec_o
);
  slot_state_e       state_q [DEPTH];
  logic [DATA_W-1:0] data_q  [DEPTH];

  logic [DEPTH-1:0] free_v, new_v, retx_v;
  logic             free_found, new_found, retx_found;
  logic [TAG_W-1:0] free_idx, new_idx, retx_idx;
  logic             alloc;

  for (genvar g = 0; g < DEPTH; g++) begin : g_vec
    assign free_v[g] = (state_q[g] == SLOT_FREE);
    assign new_v[g]  = (state_q[g] == SLOT_NEW);
    assign retx_v[g] = (state_q[g] == SLOT_RETX);
  end

  scl_lowest_pick #(.N(DEPTH), .IDX_W(TAG_W)) u_pick_free (
    .req_i(free_v), .found_o(free_found), .idx_o(free_idx));
  scl_lowest_pick #(.N(DEPTH), .IDX_W(TAG_W)) u_pick_new (
    .req_i(new_v), .found_o(new_found), .idx_o(new_idx));
  scl_lowest_pick #(.N(DEPTH), .IDX_W(TAG_W)) u_pick_retx (
    .req_i(retx_v), .found_o(retx_found), .idx_o(retx_idx));

  // refused cells first, then credited new cells, then one speculative new cell
  always_comb begin
    send_o      = 1'b0;
    send_spec_o = 1'b0;
    send_tag_o  = '0;
    if (credit_ok_i && retx_found) begin
      send_o     = 1'b1;
      send_tag_o = retx_idx;
    end else if (new_found) begin
      send_o      = 1'b1;
      send_tag_o  = new_idx;
      send_spec_o = !credit_ok_i;
    end
  end

  assign send_data_o = data_q[send_tag_o];
  assign up_ready_o  = free_found;
  assign alloc       = up_valid_i && free_found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) state_q[i] <= SLOT_FREE;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc && free_idx == TAG_W'(i))
          state_q[i] <= SLOT_NEW;
        else if (send_o && send_tag_o == TAG_W'(i))
          state_q[i] <= SLOT_WAIT;
        else if ((ack_i || nack_i) && resp_tag_i == TAG_W'(i))
          state_q[i] <= nack_i ? SLOT_RETX : SLOT_FREE;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc) data_q[free_idx] <= up_data_i;
  end
endmodule

// File: rtl/scl_rx_buffer.sv
module scl_rx_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int TAG_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_valid_i,
  input  logic [DATA_W-1:0] cell_data_i,
  input  logic [TAG_W-1:0]  cell_tag_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              ack_o,
  output logic              nack_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              credit_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, push, pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // full is judged on the arrival cycle alone; a same-cycle pop does not count
  assign full        = (cnt_q == CNT_W'(DEPTH));
  assign push        = cell_valid_i && !full;
  assign out_valid_o = (cnt_q != '0);
  assign pop         = out_valid_o && out_ready_i;
  assign out_data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q     <= '0;
      rd_q     <= '0;
      cnt_q    <= '0;
      ack_o    <= 1'b0;
      nack_o   <= 1'b0;
      tag_o    <= '0;
      credit_o <= 1'b0;
    end else begin
      if (push) wr_q <= ptr_inc(wr_q);
      if (pop)  rd_q <= ptr_inc(rd_q);
      cnt_q    <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      ack_o    <= push;
      nack_o   <= cell_valid_i && full;
      if (cell_valid_i) tag_o <= cell_tag_i;
      credit_o <= pop;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_q] <= cell_data_i;
  end
endmodule

// File: rtl/spec_credit_link.sv
module spec_credit_link #(
  parameter int DATA_W      = 8,
  parameter int STORE_DEPTH = 4,
  parameter int RX_DEPTH    = 2,
  localparam int TAG_W      = (STORE_DEPTH > 1) ? $clog2(STORE_DEPTH) : 1,
  localparam int CNT_W      = $clog2(STORE_DEPTH + RX_DEPTH + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_valid_i,
  input  logic [DATA_W-1:0] up_data_i,
  output logic              up_ready_o,
  output logic              link_valid_o,
  output logic [DATA_W-1:0] link_data_o,
  output logic [TAG_W-1:0]  link_tag_o,
  output logic              link_spec_o,
  output logic              resp_ack_o,
  output logic              resp_nack_o,
  output logic [TAG_W-1:0]  resp_tag_o,
  output logic              resp_credit_o,
  output logic              cons_valid_o,
  output logic [DATA_W-1:0] cons_data_o,
  input  logic              cons_ready_i
);
  logic                    send, send_spec, credit_ok;
  logic [TAG_W-1:0]        send_tag;
  logic [DATA_W-1:0]       send_data;
  logic signed [CNT_W-1:0] credit_q;

  scl_credit_ctr #(.CNT_W(CNT_W), .INIT(RX_DEPTH)) u_credit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (send),
    .give_nack_i (resp_nack_o),
    .give_pop_i  (resp_credit_o),
    .credit_o    (credit_q),
    .credit_ok_o (credit_ok)
  );

  scl_tx_store #(.DATA_W(DATA_W), .DEPTH(STORE_DEPTH), .TAG_W(TAG_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .up_valid_i  (up_valid_i),
    .up_data_i   (up_data_i),
    .up_ready_o  (up_ready_o),
    .credit_ok_i (credit_ok),
    .ack_i       (resp_ack_o),
    .nack_i      (resp_nack_o),
    .resp_tag_i  (resp_tag_o),
    .send_o      (send),
    .send_tag_o  (send_tag),
    .send_data_o (send_data),
    .send_spec_o (send_spec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_valid_o <= 1'b0;
      link_spec_o  <= 1'b0;
      link_tag_o   <= '0;
      link_data_o  <= '0;
    end else begin
      link_valid_o <= send;
      link_spec_o  <= send && send_spec;
      if (send) begin
        link_tag_o  <= send_tag;
        link_data_o <= send_data;
      end
    end
  end

  scl_rx_buffer #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH), .TAG_W(TAG_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cell_valid_i (link_valid_o),
    .cell_data_i  (link_data_o),
    .cell_tag_i   (link_tag_o),
    .out_ready_i  (cons_ready_i),
    .out_valid_o  (cons_valid_o),
    .out_data_o   (cons_data_o),
    .ack_o        (resp_ack_o),
    .nack_o       (resp_nack_o),
    .tag_o        (resp_tag_o),
    .credit_o     (resp_credit_o)
  );
endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
  parameter int CNT_W = 4,
  parameter int TAG_W = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    link_valid_i,
  input logic                    link_spec_i,
  input logic [TAG_W-1:0]        link_tag_i,
  input logic signed [CNT_W-1:0] credit_i,
  input logic                    resp_ack_i,
  input logic                    resp_nack_i,
  input logic [TAG_W-1:0]        resp_tag_i,
  input logic                    resp_credit_i,
  input logic                    cons_valid_i,
  input logic                    cons_ready_i
);
  logic credit_le0;
  assign credit_le0 = credit_i[CNT_W-1] || (credit_i == '0);

  a_r7_ack_nack_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resp_ack_i && resp_nack_i));

  a_r7_every_cell_answered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_i |=> (resp_ack_i || resp_nack_i));

  a_r7_answer_has_cell: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_ack_i || resp_nack_i) |-> ($past(link_valid_i) && resp_tag_i == $past(link_tag_i)));

  a_r8_credit_after_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_valid_i && cons_ready_i) |=> resp_credit_i);

  a_r8_no_stray_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_credit_i |-> $past(cons_valid_i && cons_ready_i));

  a_r2_credited_send_had_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_valid_i && !link_spec_i) |-> !$past(credit_le0));

  a_r3_spec_send_without_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_valid_i && link_spec_i) |-> $past(credit_le0));

  a_r9_credited_never_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_valid_i && !link_spec_i) |=> !resp_nack_i);

  a_r10_cell_held_until_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_valid_i && !cons_ready_i) |=> cons_valid_i);
endmodule

bind spec_credit_link scl_checker #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .link_valid_i  (link_valid_o),
  .link_spec_i   (link_spec_o),
  .link_tag_i    (link_tag_o),
  .credit_i      (credit_q),
  .resp_ack_i    (resp_ack_o),
  .resp_nack_i   (resp_nack_o),
  .resp_tag_i    (resp_tag_o),
  .resp_credit_i (resp_credit_o),
  .cons_valid_i  (cons_valid_o),
  .cons_ready_i  (cons_ready_i)
);

// File: tb/tb_spec_credit_link.sv
module tb_spec_credit_link;
  localparam int DW    = 16;
  localparam int SD    = 4;
  localparam int RD    = 2;
  localparam int TW    = 2;
  localparam int NCELL = 24;
  localparam int MAXC  = 2048;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, up_valid, up_ready, cons_ready;
  logic [DW-1:0] up_data, link_data, cons_data;
  logic          link_valid, link_spec, resp_ack, resp_nack, resp_credit, cons_valid;
  logic [TW-1:0] link_tag, resp_tag;

  spec_credit_link #(.DATA_W(DW), .STORE_DEPTH(SD), .RX_DEPTH(RD)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .up_valid_i(up_valid), .up_data_i(up_data), .up_ready_o(up_ready),
    .link_valid_o(link_valid), .link_data_o(link_data), .link_tag_o(link_tag),
    .link_spec_o(link_spec),
    .resp_ack_o(resp_ack), .resp_nack_o(resp_nack), .resp_tag_o(resp_tag),
    .resp_credit_o(resp_credit),
    .cons_valid_o(cons_valid), .cons_data_o(cons_data), .cons_ready_i(cons_ready)
  );

  int vectors = 0, miscompares = 0;
  int sent_cnt [MAXC];
  int spec_cnt [MAXC];
  int deliv    [MAXC];
  int retx_since [MAXC];
  int tag_data [SD];
  bit last_spec [SD];

  int credit_m, occ_prev, kcyc, next_data, accepted, acked, delivered, scen_base;
  int lt_prev, pop_data, scen_acc, scen_cyc;
  bit rc_prev, rn_prev, pop_prev, lv_prev, hs_pend;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, kcyc);
    end
  endtask

  task automatic observe();
    int d, occ_now, held;
    bit bad;
    kcyc++;
    if (hs_pend) begin accepted++; next_data++; scen_acc++; end

    held = accepted - acked;
    chk(up_ready == (held < SD), "R1 ready tracks free slots", up_ready, held < SD);

    chk(!(resp_ack && resp_nack), "R7 one answer per cell", resp_ack + resp_nack, 1);
    if (resp_ack || resp_nack) begin
      chk(lv_prev, "R7 answer follows a cell", lv_prev, 1);
      chk(resp_tag == lt_prev, "R7 answer tag", resp_tag, lt_prev);
    end
    if (resp_nack) begin
      chk(occ_prev == RD, "R7 drop only when full", occ_prev, RD);
      d = tag_data[resp_tag];
      chk(last_spec[resp_tag], "R9 credited cell dropped", last_spec[resp_tag], 1);
      retx_since[d] = kcyc;
    end
    if (resp_ack) chk(occ_prev < RD, "R7 ack only with room", occ_prev, RD - 1);
    chk(resp_credit == pop_prev, "R8 credit after pop", resp_credit, pop_prev);
    if (pop_prev) begin
      chk(deliv[pop_data] == 0 && sent_cnt[pop_data] > 0 && pop_data < next_data,
          "R9 delivered once", deliv[pop_data], 0);
      deliv[pop_data]++;
      delivered++;
    end
    occ_now = occ_prev + resp_ack - pop_prev;
    chk(cons_valid == (occ_now > 0), "R10 valid iff nonempty", cons_valid, occ_now > 0);

    if (link_valid) begin
      d = link_data;
      chk(d < next_data && d >= scen_base, "R9 only accepted data", d, next_data - 1);
      if (d < MAXC) begin
        if (link_spec) begin
          chk(credit_m <= 0, "R3 speculative only at zero credit", credit_m, 0);
          chk(sent_cnt[d] == 0, "R4 speculative only on first send", sent_cnt[d], 0);
        end else begin
          chk(credit_m > 0, "R2 credited send needs credit", credit_m, 1);
        end
        if (sent_cnt[d] > 0) begin
          chk(retx_since[d] >= 0, "R6 resend only after nack", retx_since[d], 0);
          chk(!link_spec, "R5 resend uses credit", link_spec, 0);
          retx_since[d] = -1;
        end else if (!link_spec) begin
          bad = 1'b0;
          for (int e = scen_base; e < next_data; e++)
            if (retx_since[e] >= 0 && retx_since[e] <= kcyc - 2) bad = 1'b1;
          chk(!bad, "R5 resend before new cell", bad, 0);
        end
        sent_cnt[d]++;
        spec_cnt[d] += link_spec;
        chk(spec_cnt[d] <= 1, "R4 at most one speculative send", spec_cnt[d], 1);
        tag_data[link_tag] = d;
        last_spec[link_tag] = link_spec;
      end
    end

    if (resp_ack) acked++;
    credit_m = credit_m - link_valid + rc_prev + rn_prev;
    rc_prev  = resp_credit;
    rn_prev  = resp_nack;
    lv_prev  = link_valid;
    lt_prev  = link_tag;
    occ_prev = occ_now;
  endtask

  task automatic drive(input logic [3:0] umask, input logic [3:0] rmask);
    up_valid   = umask[kcyc % 4] && (scen_acc < NCELL);
    up_data    = DW'(next_data);
    cons_ready = rmask[kcyc % 4] || (scen_cyc >= 60);
    #1;
    hs_pend  = up_valid && up_ready;
    pop_prev = cons_ready && cons_valid;
    pop_data = cons_data;
  endtask

  initial begin
    for (int i = 0; i < MAXC; i++) begin
      sent_cnt[i] = 0; spec_cnt[i] = 0; deliv[i] = 0; retx_since[i] = -1;
    end
    rst_n = 1'b0; up_valid = 1'b0; up_data = '0; cons_ready = 1'b0;
    credit_m = RD; occ_prev = 0; kcyc = 0; next_data = 0; accepted = 0; acked = 0;
    delivered = 0; scen_base = 0; lt_prev = 0; pop_data = 0; scen_acc = 0; scen_cyc = 0;
    rc_prev = 0; rn_prev = 0; pop_prev = 0; lv_prev = 0; hs_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(up_ready == 1'b1, "R1 reset ready", up_ready, 1);
    chk(!link_valid && !cons_valid, "R1 reset idle", link_valid + cons_valid, 0);
    chk(!resp_ack && !resp_nack && !resp_credit, "R1 reset responses",
        resp_ack + resp_nack + resp_credit, 0);

    for (int r = 0; r < 16; r++) begin
      for (int u = 0; u < 3; u++) begin
        logic [3:0] um;
        um = (u == 0) ? 4'b1111 : (u == 1) ? 4'b0101 : 4'b0011;
        scen_base = next_data;
        scen_acc  = 0;
        scen_cyc  = 0;
        while (scen_cyc < 600 &&
               !(scen_acc == NCELL && delivered == accepted && accepted == acked &&
                 occ_prev == 0 && !hs_pend)) begin
          @(negedge clk);
          observe();
          drive(um, 4'(r));
          scen_cyc++;
        end
        chk(delivered == accepted && scen_acc == NCELL, "R9 all cells delivered",
            delivered, accepted);
        chk(up_ready == 1'b1, "R1 store empties", up_ready, 1);
      end
    end
    up_valid = 1'b0;
    cons_ready = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", kcyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule